// File: doc/BRIEF.md
# Handshaked Byte Output Port

This block is a latched byte output port with a two-wire handshake to a peripheral. The host writes a byte with an active-low write strobe. The block latches the byte and drives it on its output pins without a break. It then pulls the active-low buffer-full flag low to tell the peripheral that a new byte is waiting.

The peripheral takes the byte by pulsing an active-low acknowledge. The start of the acknowledge releases the buffer-full flag. When the acknowledge ends, the block can raise an interrupt to ask the host for the next byte.

Both strobes may come from another clock domain, so each passes through a two-flop synchronizer. A minimum-width filter screens the acknowledge. A register-select input steers a host write to one of two places:
- the data latch (select low);
- the interrupt-enable bit (select high, bit 0 of the bus).

Top module: `strobed_out_port`

## Requirements
- R1: After reset the output pins are all zero, the buffer-full flag `full_n` is high, `irq` is low and the interrupt enable is cleared.
- R2: A write strobe with `reg_sel` = 0 latches the bus byte when the strobe rises. Within four clocks of that rise, `pout` shows the byte and `full_n` is low.
- R3: An accepted acknowledge drives `full_n` high while the acknowledge is still low, and leaves `pout` unchanged.
- R4: When an accepted acknowledge returns high, a pending interrupt request is recorded. `irq` stays low if the enable is clear.
- R5: The falling edge of a write strobe with `reg_sel` = 0 clears the pending interrupt request, and `irq` with it.
- R6: A write with `reg_sel` = 1 loads the interrupt enable from `din` bit 0. It changes neither `pout` nor `full_n`, and it does not clear a pending request.
- R7: A data write while `full_n` is already low overwrites the latch, and `full_n` stays low.
- R8: An acknowledge that stays low for fewer than `ACK_MIN` clocks after synchronization is ignored. It changes neither `full_n` nor the interrupt request.
- R9: `irq` is the AND of the interrupt enable and the pending request. Clearing the enable masks a pending request, and setting the enable again shows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_n | input | 1 | Host write strobe, active low, asynchronous |
| reg_sel | input | 1 | 0 selects the data latch, 1 selects the interrupt-enable bit |
| din | input | W | Host data bus |
| ack_n | input | 1 | Peripheral acknowledge, active low, asynchronous |
| pout | output | W | Latched output byte |
| full_n | output | 1 | Buffer-full flag, active low |
| irq | output | 1 | Interrupt request to the host |

## Verification
Random sequences mix four kinds of operation:
- data writes;
- enable writes with either value of bit 0;
- full-length acknowledges;
- single-clock acknowledge glitches.

A reference model in the bench predicts all three outputs after each operation. The glitches separate a filtered acknowledge from an unfiltered one. Writes that land while the buffer is full separate overwrite from drop. Enable writes made while a request is pending show whether the request is kept, masked, or wrongly cleared. Directed cases at the start cover these paths in a fixed order: an acknowledge with the enable clear, enabling while a request is pending, a back-to-back overwrite, and disabling then re-enabling.

// File: rtl/strobed_out_port.sv
module strobed_out_port #(
  parameter int W       = 8,
  parameter int ACK_MIN = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_n,
  input  logic         reg_sel,
  input  logic [W-1:0] din,
  input  logic         ack_n,
  output logic [W-1:0] pout,
  output logic         full_n,
  output logic         irq
);
  localparam int CW = $clog2(ACK_MIN + 1);

  logic [1:0]    wr_sy, ack_sy;
  logic          wr_d, ackf, ackf_d;
  logic [CW-1:0] acnt;
  logic [W-1:0]  sh_d, lat_q;
  logic          sh_sel, ie_q, arm_q, full_q;

  wire wr_s     = wr_sy[1];
  wire wr_rise  = wr_s & ~wr_d;
  wire wr_fall  = ~wr_s & wr_d;
  wire ack_fall = ~ackf & ackf_d;
  wire ack_rise = ackf & ~ackf_d;
  wire data_wr  = wr_rise & ~sh_sel;
  wire ie_wr    = wr_rise & sh_sel;
  wire req_clr  = wr_fall & ~reg_sel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_sy  <= 2'b11;
      ack_sy <= 2'b11;
      wr_d   <= 1'b1;
      ackf_d <= 1'b1;
    end else begin
      wr_sy  <= {wr_sy[0], wr_n};
      ack_sy <= {ack_sy[0], ack_n};
      wr_d   <= wr_s;
      ackf_d <= ackf;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acnt <= '0;
      ackf <= 1'b1;
    end else if (ack_sy[1]) begin
      acnt <= '0;
      ackf <= 1'b1;
    end else if (acnt == CW'(ACK_MIN - 1)) begin
      ackf <= 1'b0;
    end else begin
      acnt <= acnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_d   <= '0;
      sh_sel <= 1'b0;
    end else if (!wr_s) begin
      sh_d   <= din;
      sh_sel <= reg_sel;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat_q  <= '0;
      full_q <= 1'b1;
      ie_q   <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      if (data_wr) lat_q <= sh_d;
      if (data_wr) full_q <= 1'b0;
      else if (ack_fall) full_q <= 1'b1;
      if (ie_wr) ie_q <= sh_d[0];
      if (req_clr) arm_q <= 1'b0;
      else if (ack_rise) arm_q <= 1'b1;
    end
  end

  assign pout   = lat_q;
  assign full_n = full_q;
  assign irq    = ie_q & arm_q;
endmodule

module strobed_out_port_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] pout,
  input logic         full_n,
  input logic         irq,
  input logic         data_wr,
  input logic         ie_wr,
  input logic         ack_fall,
  input logic         ack_rise,
  input logic         req_clr
);
  AST_FULL_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(full_n) |-> $past(data_wr)); // R2
  AST_EMPTY_FROM_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full_n) |-> $past(ack_fall)); // R3
  AST_PORT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(data_wr) |-> $stable(pout)); // R3
  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(ack_rise) || $past(ie_wr))); // R4
  AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req_clr) |-> !irq); // R5
  AST_FULL_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |=> !full_n); // R7
endmodule

bind strobed_out_port strobed_out_port_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pout(pout), .full_n(full_n), .irq(irq),
  .data_wr(data_wr), .ie_wr(ie_wr), .ack_fall(ack_fall),
  .ack_rise(ack_rise), .req_clr(req_clr)
);

// File: tb/test_strobed_out_port.sv
module test_strobed_out_port;
  logic clk = 1'b0, rst_n = 1'b0, wr_n = 1'b1, reg_sel = 1'b0, ack_n = 1'b1;
  logic [7:0] din = '0;
  logic [7:0] pout;
  logic full_n, irq;
  int checks = 0, fails = 0;

  logic [7:0] m_port = '0;
  logic m_full_n = 1'b1, m_ie = 1'b0, m_arm = 1'b0;

  always #2 clk = ~clk;

  strobed_out_port #(.W(8), .ACK_MIN(2)) i_strobed_out_port (
    .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .reg_sel(reg_sel), .din(din),
    .ack_n(ack_n), .pout(pout), .full_n(full_n), .irq(irq)
  );

  function automatic logic exp_irq(logic ie, logic arm);
    return ie & arm;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all(string req);
    chk(req, 32'(pout), 32'(m_port));
    chk(req, 32'(full_n), 32'(m_full_n));
    chk(req, 32'(irq), 32'(exp_irq(m_ie, m_arm)));
  endtask

  task automatic do_write(logic s, logic [7:0] d);
    @(negedge clk);
    reg_sel = s; din = d; wr_n = 1'b0;
    if (!s) m_arm = 1'b0;
    repeat (3) @(negedge clk);
    wr_n = 1'b1;
    repeat (6) @(negedge clk);
    din = 8'($urandom);
    if (s) m_ie = d[0];
    else begin m_port = d; m_full_n = 1'b0; end
  endtask

  task automatic do_ack(int len);
    @(negedge clk);
    ack_n = 1'b0;
    repeat (len) @(negedge clk);
    if (len >= 6) chk("R3", 32'(full_n), 32'd1);
    ack_n = 1'b1;
    repeat (6) @(negedge clk);
    if (len >= 2) begin m_full_n = 1'b1; m_arm = 1'b1; end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd7));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_all("R1");
    do_ack(8);          check_all("R4");
    chk("R1", 32'(irq), 32'd0);
    do_write(1'b1, 8'h01); check_all("R9");
    chk("R9", 32'(irq), 32'd1);
    do_write(1'b0, 8'hA5); check_all("R5");
    chk("R2", 32'(pout), 32'hA5);
    do_write(1'b0, 8'h3C); check_all("R7");
    chk("R7", 32'(full_n), 32'd0);
    do_ack(1);          check_all("R8");
    chk("R8", 32'(full_n), 32'd0);
    do_ack(7);          check_all("R3");
    chk("R4", 32'(irq), 32'd1);
    do_write(1'b1, 8'hFF); check_all("R6");
    chk("R6", 32'(irq), 32'd1);
    do_write(1'b1, 8'hFE); check_all("R9");
    chk("R6", 32'(pout), 32'h3C);
    do_write(1'b1, 8'h01); check_all("R9");

    for (int i = 0; i < 300; i++) begin
      int op = int'($urandom_range(0, 3));
      case (op)
        0: begin do_write(1'b0, 8'($urandom)); check_all("R2"); end
        1: begin do_write(1'b1, 8'($urandom)); check_all("R6"); end
        2: begin do_ack(int'($urandom_range(6, 10))); check_all("R4"); end
        default: begin do_ack(1); check_all("R8"); end
      endcase
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule